// File: doc/BRIEF.md
# PWM Bridge Output Steering

This block produces one pulse-width-modulated waveform and routes it onto four output pins, named A to D, so that one waveform can drive a single switch, a half-bridge or a full bridge. The time base is a 10-bit counter. Its upper 8 bits run from zero up to a programmable period, and its lower 2 bits are a fine phase that advances on every clock. One period therefore lasts (period + 1) * 4 clocks. The duty value is also 10 bits wide: an 8-bit coarse part and a 2-bit fine part.

A 2-bit bridge selector chooses one of four routings. Single-ended modulates only A. Half-bridge drives A and B as a complementary pair, with a programmable dead time between them. Full-bridge forward modulates D and holds A on. Full-bridge reverse modulates B and holds C on. Two polarity bits set the active level of the A/C pair and of the B/D pair. A per-pin drive mask reports which pins the block owns in the current routing. Pins that are not owned are free to act as ordinary port pins. Period and duty updates take effect only at the period boundary, so a change never produces a short or partial pulse.

Top module: `pwm_bridge_steer`

## Requirements
- R1: The counter runs from 0 to the terminal count {period, 2'b11} and then returns to 0, so one period is (period + 1) * 4 clocks. `period_end` is high for exactly one clock in each period, on the clock where the counter holds the terminal count.
- R2: The modulated waveform is active for D clocks per period, where D = duty_hi * 4 + duty_lo. D = 0 gives a waveform that is never active. A D greater than the terminal count gives a waveform that is active for the whole period.
- R3: A new period or duty value written in the middle of a period takes effect only when the counter wraps. The period in progress keeps the old values until it ends.
- R4: With `bridge_sel` = 2'b00 (single), A carries the modulated waveform, B, C and D stay inactive, and `pin_drv` = 4'b0001.
- R5: With `bridge_sel` = 2'b10 (half-bridge), A follows the waveform and B is its complement, and `pin_drv` = 4'b0011. At every transition, both pins stay inactive for `dead_time` clocks before the rising pin asserts. Per period, A is active for D - dead_time clocks and B for L - D - dead_time clocks, where L is the period length.
- R6: In half-bridge mode, A and B are never active in the same clock.
- R7: With `bridge_sel` = 2'b01 (full forward), D carries the waveform, A is held active, B and C are held inactive, and `pin_drv` = 4'b1111.
- R8: With `bridge_sel` = 2'b11 (full reverse), B carries the waveform, C is held active, A and D are held inactive, and `pin_drv` = 4'b1111.
- R9: Bit 1 of `pol_sel` makes A and C active-low. Bit 0 makes B and D active-low. Each pin level equals its active state XOR its polarity bit.
- R10: Every pin whose `pin_drv` bit (bit 0 = A up to bit 3 = D) is 0 sits at its inactive level.
- R11: While `run` is low, `pin_drv` is 0, all pins sit at their inactive level and the counter is held at 0. After `run` rises, the first `period_end` comes L - 1 clocks later.
- R12: During synchronous reset, `pin_out` and `pin_drv` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables the time base and the outputs |
| period | input | 8 | Coarse period (terminal value of the upper counter bits) |
| duty_hi | input | 8 | Coarse duty bits |
| duty_lo | input | 2 | Fine duty bits |
| bridge_sel | input | 2 | Routing: 00 single, 10 half, 01 full forward, 11 full reverse |
| pol_sel | input | 2 | Bit 1 makes A/C active-low, bit 0 makes B/D active-low |
| dead_time | input | 7 | Dead time in clocks for half-bridge mode |
| pin_out | output | 4 | Pin levels, bit 0 = A to bit 3 = D |
| pin_drv | output | 4 | Per-pin drive mask, 1 = owned by this block |
| period_end | output | 1 | High on the terminal-count clock |

## Verification
The hardest behaviour to reach from the ports is the dead time in half-bridge mode. It appears only around the two waveform edges, and it lags the counter by two register stages. The bench does not try to align to the exact edge cycle. Instead, after two period boundaries the pattern repeats exactly, so the bench counts active clocks on A, on B, on both and on neither over one full period. Those four counts fix the dead time on both edges, whatever the pipeline latency is. The mid-period duty change is reached by syncing to `period_end` and writing the new value one clock after the wrap.

// File: rtl/pwm_steer_pkg.sv
// Shared types for the PWM bridge steering block.
// Assumes pin order A, B, C, D maps onto bit 0 through bit 3.
package pwm_steer_pkg;

    typedef enum logic [1:0] {
        BR_SINGLE = 2'b00,
        BR_FWD    = 2'b01,
        BR_HALF   = 2'b10,
        BR_REV    = 2'b11
    } bridge_e;

    localparam int PIN_A = 0;
    localparam int PIN_B = 1;
    localparam int PIN_C = 2;
    localparam int PIN_D = 3;
    localparam int NUM_PINS = 4;

endpackage

// File: rtl/pwm_timebase.sv
// Period counter and duty comparator.
// The counter is {coarse, fine}. It wraps at {period, all-ones fine}.
// Period and duty are captured at the wrap, or continuously while run is low.
// Assumes period and duty stay stable for at least the capturing clock.
module pwm_timebase #(
    parameter int COARSE_W = 8,
    parameter int FINE_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic [COARSE_W-1:0]          period,
    input  logic [COARSE_W-1:0]          duty_hi,
    input  logic [FINE_W-1:0]            duty_lo,
    output logic [COARSE_W+FINE_W-1:0]   cnt,
    output logic [COARSE_W-1:0]          per_cur,
    output logic [COARSE_W+FINE_W-1:0]   duty_cur,
    output logic                         wrap,
    output logic                         raw
);
    localparam int CW = COARSE_W + FINE_W;

    logic [CW-1:0] term;

    // Terminal count built from the captured period.
    assign term = {per_cur, {FINE_W{1'b1}}};
    assign wrap = (cnt == term);
    // Waveform is active while the count is below the captured duty.
    assign raw  = (cnt < duty_cur);

    // Advance the counter and capture the new settings at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            per_cur  <= '0;
            duty_cur <= '0;
        end else if (!run) begin
            cnt      <= '0;
            per_cur  <= period;
            duty_cur <= {duty_hi, duty_lo};
        end else if (wrap) begin
            cnt      <= '0;
            per_cur  <= period;
            duty_cur <= {duty_hi, duty_lo};
        end else begin
            cnt      <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_dead_band.sv
// Splits the raw waveform into a complementary pair with dead time.
// On each edge of raw, both outputs drop for dead clocks, then the
// output that follows the new level asserts. A zero dead time switches
// at once. It also gives a one-clock delayed copy of raw, so that the
// other routings have the same latency.
// Assumes dead is held stable while a dead interval is running.
module pwm_dead_band #(
    parameter int DB_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DB_W-1:0] dead,
    output logic            mod_q,
    output logic            a_on,
    output logic            b_on
);
    logic            raw_prev;
    logic [DB_W-1:0] tmr;
    logic            edge_seen;

    // An edge is any change of raw against the previous clock.
    assign edge_seen = (raw != raw_prev);

    // Delay raw by one clock and run the dead-time timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_prev <= 1'b0;
            mod_q    <= 1'b0;
            tmr      <= '0;
            a_on     <= 1'b0;
            b_on     <= 1'b0;
        end else begin
            raw_prev <= raw;
            mod_q    <= raw;
            if (edge_seen) begin
                if (dead == '0) begin
                    tmr  <= '0;
                    a_on <= raw;
                    b_on <= !raw;
                end else begin
                    tmr  <= dead - 1'b1;
                    a_on <= 1'b0;
                    b_on <= 1'b0;
                end
            end else if (tmr != '0) begin
                tmr  <= tmr - 1'b1;
                a_on <= 1'b0;
                b_on <= 1'b0;
            end else begin
                a_on <= raw;
                b_on <= !raw;
            end
        end
    end

endmodule

// File: rtl/pwm_pin_steer.sv
// Routes the modulated signals onto pins A-D for the selected bridge
// mode, applies the per-pair polarity, and registers the pin levels and
// the drive mask. Pins that are not driven output their inactive level.
// Assumes mod, a_on and b_on come from registers with equal latency.
module pwm_pin_steer
    import pwm_steer_pkg::*;
#(
    parameter int NP = NUM_PINS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    bridge_sel,
    input  logic [1:0]    pol_sel,
    input  logic          mod,
    input  logic          a_on,
    input  logic          b_on,
    output logic [NP-1:0] pin_out,
    output logic [NP-1:0] pin_drv
);
    bridge_e       mode;
    logic [NP-1:0] act;
    logic [NP-1:0] drv;
    logic [NP-1:0] inv;

    assign mode = bridge_e'(bridge_sel);

    // Even pins (A, C) take the upper polarity bit, odd pins (B, D) the lower.
    for (genvar i = 0; i < NP; i++) begin : g_pol
        if ((i % 2) == 0) begin : g_even
            assign inv[i] = pol_sel[1];
        end else begin : g_odd
            assign inv[i] = pol_sel[0];
        end
    end

    // Active state and ownership of each pin for the selected routing.
    always_comb begin
        act = '0;
        drv = '0;
        if (run) begin
            case (mode)
                BR_SINGLE: begin
                    act[PIN_A] = mod;
                    drv[PIN_A] = 1'b1;
                end
                BR_HALF: begin
                    act[PIN_A] = a_on;
                    act[PIN_B] = b_on;
                    drv[PIN_A] = 1'b1;
                    drv[PIN_B] = 1'b1;
                end
                BR_FWD: begin
                    act[PIN_A] = 1'b1;
                    act[PIN_D] = mod;
                    drv        = '1;
                end
                BR_REV: begin
                    act[PIN_C] = 1'b1;
                    act[PIN_B] = mod;
                    drv        = '1;
                end
                default: begin
                    act = '0;
                    drv = '0;
                end
            endcase
        end
    end

    // Register the pin levels with polarity applied, and the drive mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= '0;
            pin_drv <= '0;
        end else begin
            pin_out <= act ^ inv;
            pin_drv <= drv;
        end
    end

endmodule

// File: rtl/pwm_bridge_steer.sv
// Top level: time base, dead-band splitter and pin steering.
// The pins lag the counter by two clocks (splitter and steering registers).
// Assumes a single clock domain and a synchronous active-low reset.
module pwm_bridge_steer
    import pwm_steer_pkg::*;
#(
    parameter int COARSE_W = 8,
    parameter int FINE_W   = 2,
    parameter int DB_W     = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [COARSE_W-1:0] period,
    input  logic [COARSE_W-1:0] duty_hi,
    input  logic [FINE_W-1:0]   duty_lo,
    input  logic [1:0]          bridge_sel,
    input  logic [1:0]          pol_sel,
    input  logic [DB_W-1:0]     dead_time,
    output logic [3:0]          pin_out,
    output logic [3:0]          pin_drv,
    output logic                period_end
);
    localparam int CW = COARSE_W + FINE_W;

    logic [CW-1:0]       cnt_cur;
    logic [COARSE_W-1:0] period_cur;
    logic [CW-1:0]       duty_cur;
    logic                wrap;
    logic                raw;
    logic                mod_q;
    logic                a_on;
    logic                b_on;

    pwm_timebase #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .period   (period),
        .duty_hi  (duty_hi),
        .duty_lo  (duty_lo),
        .cnt      (cnt_cur),
        .per_cur  (period_cur),
        .duty_cur (duty_cur),
        .wrap     (wrap),
        .raw      (raw)
    );

    pwm_dead_band #(.DB_W(DB_W)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .dead  (dead_time),
        .mod_q (mod_q),
        .a_on  (a_on),
        .b_on  (b_on)
    );

    pwm_pin_steer #(.NP(NUM_PINS)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .bridge_sel (bridge_sel),
        .pol_sel    (pol_sel),
        .mod        (mod_q),
        .a_on       (a_on),
        .b_on       (b_on),
        .pin_out    (pin_out),
        .pin_drv    (pin_drv)
    );

    assign period_end = wrap;

endmodule

// File: rtl/pwm_bridge_steer_chk.sv
// Assertion checker for pwm_bridge_steer. It is attached with bind below.
module pwm_bridge_steer_chk #(
    parameter int COARSE_W = 8,
    parameter int FINE_W   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run,
    input logic [1:0]                 bridge_sel,
    input logic [1:0]                 pol_sel,
    input logic [3:0]                 pin_out,
    input logic [3:0]                 pin_drv,
    input logic                       period_end,
    input logic [COARSE_W+FINE_W-1:0] cnt_cur,
    input logic [COARSE_W-1:0]        period_cur,
    input logic [COARSE_W+FINE_W-1:0] duty_cur
);
    logic [3:0] inv_now;
    assign inv_now = {pol_sel[0], pol_sel[1], pol_sel[0], pol_sel[1]};

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_cur <= {period_cur, {FINE_W{1'b1}}});

    // R3
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !period_end) |=> ($stable(duty_cur) && $stable(period_cur)));

    // R4
    single_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bridge_sel == 2'b00) |=> (pin_drv == 4'b0001));

    // R6
    half_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bridge_sel == 2'b10) |=>
        !((pin_out[0] ^ $past(pol_sel[1])) && (pin_out[1] ^ $past(pol_sel[0]))));

    // R7
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bridge_sel == 2'b01) |=>
        (pin_drv == 4'b1111 && (pin_out[0] ^ $past(pol_sel[1]))
         && !(pin_out[1] ^ $past(pol_sel[0])) && !(pin_out[2] ^ $past(pol_sel[1]))));

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((pin_out ^ $past(inv_now)) & ~pin_drv) == 4'b0000));

    // R11
    off_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pin_drv == 4'b0000));

endmodule

bind pwm_bridge_steer pwm_bridge_steer_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .bridge_sel (bridge_sel),
    .pol_sel    (pol_sel),
    .pin_out    (pin_out),
    .pin_drv    (pin_drv),
    .period_end (period_end),
    .cnt_cur    (cnt_cur),
    .period_cur (period_cur),
    .duty_cur   (duty_cur)
);

// File: tb/sim_pwm_bridge_steer.sv
module sim_pwm_bridge_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] period = 8'd9;
    logic [7:0] duty_hi = 8'd3;
    logic [1:0] duty_lo = 2'd2;
    logic [1:0] bridge_sel = 2'b00;
    logic [1:0] pol_sel = 2'b00;
    logic [6:0] dead_time = 7'd0;
    logic [3:0] pin_out;
    logic [3:0] pin_drv;
    logic       period_end;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int m_act[4];
    int m_both;
    int m_none;
    int m_drvbad;

    pwm_bridge_steer u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period),
        .duty_hi(duty_hi), .duty_lo(duty_lo), .bridge_sel(bridge_sel),
        .pol_sel(pol_sel), .dead_time(dead_time), .pin_out(pin_out),
        .pin_drv(pin_drv), .period_end(period_end)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int plen();
        return (int'(period) + 1) * 4;
    endfunction

    task automatic wait_wrap();
        do @(negedge clk); while (!period_end);
    endtask

    // Settle two boundaries, then count active clocks per pin over one period.
    task automatic measure(input logic [3:0] exp_drv);
        logic [3:0] inv;
        logic [3:0] a;
        wait_wrap();
        wait_wrap();
        inv = {pol_sel[0], pol_sel[1], pol_sel[0], pol_sel[1]};
        for (int k = 0; k < 4; k++) m_act[k] = 0;
        m_both = 0; m_none = 0; m_drvbad = 0;
        for (int c = 0; c < plen(); c++) begin
            @(negedge clk);
            a = pin_out ^ inv;
            for (int k = 0; k < 4; k++) if (a[k]) m_act[k]++;
            if (a[0] && a[1]) m_both++;
            if (!a[0] && !a[1]) m_none++;
            if (pin_drv != exp_drv) m_drvbad++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R12 pin_out in reset", int'(pin_out), 0);
        chk("R12 pin_drv in reset", int'(pin_drv), 0);
        rst_n = 1'b1;
        run = 1'b1;
    endtask

    task automatic t_timebase();
        int n;
        period = 8'd9;
        wait_wrap();
        n = 0;
        do begin @(negedge clk); n++; end while (!period_end);
        chk("R1 period length P=9", n, 40);
        @(negedge clk);
        period = 8'd3;
        n = 0;
        do begin @(negedge clk); n++; end while (!period_end);
        chk("R3 old period kept", n, 39);
        n = 0;
        do begin @(negedge clk); n++; end while (!period_end);
        chk("R1 period length P=3", n, 16);
        period = 8'd9;
        wait_wrap();
    endtask

    task automatic t_single();
        bridge_sel = 2'b00; pol_sel = 2'b00; duty_hi = 8'd3; duty_lo = 2'd2;
        measure(4'b0001);
        chk("R4 A active count", m_act[0], 14);
        chk("R2 duty 14 on A", m_act[0], 14);
        chk("R10 B,C,D idle", m_act[1] + m_act[2] + m_act[3], 0);
        chk("R4 drive mask", m_drvbad, 0);
    endtask

    task automatic t_duty_edges();
        bridge_sel = 2'b00; duty_hi = 8'd0; duty_lo = 2'd0;
        measure(4'b0001);
        chk("R2 duty zero", m_act[0], 0);
        duty_hi = 8'd10; duty_lo = 2'd0;
        measure(4'b0001);
        chk("R2 duty above period", m_act[0], 40);
    endtask

    task automatic t_duty_update();
        bridge_sel = 2'b00; duty_hi = 8'd3; duty_lo = 2'd2;
        wait_wrap(); wait_wrap();
        wait_wrap();
        @(negedge clk);
        duty_hi = 8'd6; duty_lo = 2'd1;
        m_act[0] = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (pin_out[0]) m_act[0]++;
        end
        chk("R3 old duty kept", m_act[0], 14);
        measure(4'b0001);
        chk("R3 new duty applied", m_act[0], 25);
    endtask

    task automatic t_half();
        bridge_sel = 2'b10; duty_hi = 8'd3; duty_lo = 2'd2; dead_time = 7'd3;
        measure(4'b0011);
        chk("R5 A count with dead time", m_act[0], 11);
        chk("R5 B count with dead time", m_act[1], 23);
        chk("R5 both-off clocks", m_none, 6);
        chk("R6 A and B overlap", m_both, 0);
        chk("R5 drive mask", m_drvbad, 0);
        chk("R10 C,D idle", m_act[2] + m_act[3], 0);
        dead_time = 7'd0;
        measure(4'b0011);
        chk("R5 A count zero dead", m_act[0], 14);
        chk("R5 B count zero dead", m_act[1], 26);
        chk("R6 overlap zero dead", m_both, 0);
    endtask

    task automatic t_full();
        bridge_sel = 2'b01; duty_hi = 8'd3; duty_lo = 2'd2;
        measure(4'b1111);
        chk("R7 D modulated", m_act[3], 14);
        chk("R7 A held", m_act[0], 40);
        chk("R7 B,C off", m_act[1] + m_act[2], 0);
        chk("R7 drive mask", m_drvbad, 0);
        bridge_sel = 2'b11;
        measure(4'b1111);
        chk("R8 B modulated", m_act[1], 14);
        chk("R8 C held", m_act[2], 40);
        chk("R8 A,D off", m_act[0] + m_act[3], 0);
        chk("R8 drive mask", m_drvbad, 0);
    endtask

    task automatic t_polarity();
        int lows;
        int ones;
        bridge_sel = 2'b00; pol_sel = 2'b11; duty_hi = 8'd3; duty_lo = 2'd2;
        wait_wrap(); wait_wrap();
        lows = 0; ones = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!pin_out[0]) lows++;
            if (pin_out[3:1] == 3'b111) ones++;
        end
        chk("R9 A low for duty", lows, 14);
        chk("R9 idle pins high", ones, 40);
        bridge_sel = 2'b01; pol_sel = 2'b01;
        wait_wrap(); wait_wrap();
        lows = 0; ones = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!pin_out[3]) lows++;
            if (pin_out[2:0] == 3'b011) ones++;
        end
        chk("R9 D active-low count", lows, 14);
        chk("R9 A high, B high, C low", ones, 40);
        pol_sel = 2'b00;
    endtask

    task automatic t_run_gate();
        int n;
        bridge_sel = 2'b10; pol_sel = 2'b10;
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 drive off", int'(pin_drv), 0);
        chk("R11 pins inactive", int'(pin_out), 5);
        chk("R11 no wrap", int'(period_end), 0);
        run = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!period_end);
        chk("R11 restart length", n, 39);
        pol_sel = 2'b00;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    initial begin
        t_reset();
        t_timebase();
        t_single();
        t_duty_edges();
        t_duty_update();
        t_half();
        t_full();
        t_polarity();
        t_run_gate();
        summary();
    end

endmodule